// File: doc/BRIEF.md
# Serial Video Line Encoder

This block turns 10-bit video words into a single serial line at ten times the word rate. Each word is shifted out least significant bit first. The serial stream then passes through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1, which suppresses the DC content of the line. After that it is converted from NRZ to NRZI with the polynomial x + 1, so that a long run of ones becomes a run of transitions. One bypass control removes both coding stages, and the raw serialized bits then go to the line unchanged. A lock input reports the state of the clock multiplier that feeds the bit clock. While lock is low, the line is muted.

Everything runs on the bit clock. An internal divide-by-ten counter marks the word boundaries. Words enter over a valid/ready handshake, and `word_ready` is high for one bit-clock cycle in every ten: the cycle in which the counter wraps. A word is taken when `word_valid` and `word_ready` are both high at a clock edge. A source holds its word and `word_valid` until it sees such an edge, and that wait is the only back-pressure. If no word is offered in the load cycle, an all-zero word is serialized, because the line cannot stall.

Top module: `svid_serializer`

## Requirements
- R1: While reset is held, and just after it, `sdo` is 0, `sdo_n` is 1 and `word_ready` is 0. All coding state starts at zero.
- R2: After reset, `word_ready` is high in the 10th cycle and then in every 10th cycle after that. It is never high in two consecutive cycles.
- R3: Bit k of a word accepted at edge E is the raw serial bit used at edge E+1+k (bit 0 first). The line output is registered, so the result of that bit appears on `sdo` just after that edge.
- R4: When not bypassed, each raw bit b becomes the scrambled bit s = b XOR h4 XOR h9, where hN is the scrambled bit produced N bits earlier (0 before any was produced).
- R5: When not bypassed and locked, `sdo` is the NRZI state. That state toggles on every scrambled 1 and holds on every scrambled 0.
- R6: With `bypass` = 1 and lock high, `sdo` equals the raw serial bit of that edge. The scrambler and NRZI state keep advancing during bypass.
- R7: At any edge where `lock` is 0, `sdo` becomes 0 (and `sdo_n` becomes 1).
- R8: Losing lock does not clear the scrambler or NRZI state. After lock returns, the output continues as if it had never been muted.
- R9: `sdo_n` is always the inverse of `sdo`.
- R10: If `word_valid` is 0 in a load cycle, the word serialized is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | serial bit clock |
| rst_n | input | 1 | active-low synchronous reset |
| word_data | input | 10 | parallel word to serialize |
| word_valid | input | 1 | word_data holds a word |
| word_ready | output | 1 | load cycle; the word is taken when valid is also high |
| bypass | input | 1 | 1 = skip scrambler and NRZI |
| lock | input | 1 | clock multiplier locked; 0 mutes the line |
| sdo | output | 1 | serial line, true polarity |
| sdo_n | output | 1 | serial line, complement |

## Verification
The bench builds the block with its default parameters: a 10-bit word, a 9-bit scrambler history and a tap at 4. These are the values for which the requirements define every output bit. With them, a reference model can predict the line bit for bit, and the bench compares it on every clock. At these sizes, short runs reach all the corner cases:
- all-zero and all-one words, which stress the scrambler runs;
- load slots without a word;
- lock drops in the middle of a word;
- bypass switched between words.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int unsigned WORD_BITS = 10;
  localparam int unsigned SCR_LEN   = 9;
  localparam int unsigned SCR_TAP   = 4;

  typedef struct packed {
    logic tru;
    logic cmp;
  } svid_line_t;
endpackage

// File: rtl/svid_word_timer.sv
module svid_word_timer #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_slot
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign load_slot = (cnt == LAST);
endmodule

// File: rtl/svid_shifter.sv
module svid_shifter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         word_vld,
  input  logic [W-1:0] word,
  output logic         ser_bit
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= word_vld ? word : '0;
    else           sh <= {1'b0, sh[W-1:1]};
  end

  assign ser_bit = sh[0];
endmodule

// File: rtl/svid_scrambler.sv
module svid_scrambler #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;

  assign dout = din ^ hist[TAP-1] ^ hist[LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[LEN-2:0], dout};
  end
endmodule

// File: rtl/svid_line_out.sv
module svid_line_out
  import svid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_bit,
  input  logic       raw_bit,
  input  logic       bypass,
  input  logic       lock,
  output svid_line_t line
);
  logic nrzi_q;
  logic enc;
  logic pick;

  assign enc  = scr_bit ^ nrzi_q;
  assign pick = lock & (bypass ? raw_bit : enc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrzi_q   <= 1'b0;
      line.tru <= 1'b0;
      line.cmp <= 1'b1;
    end else begin
      nrzi_q   <= enc;
      line.tru <= pick;
      line.cmp <= ~pick;
    end
  end
endmodule

// File: rtl/svid_serializer.sv
module svid_serializer
  import svid_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_BITS,
  parameter int unsigned HIST_W  = SCR_LEN,
  parameter int unsigned MID_TAP = SCR_TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              bypass,
  input  logic              lock,
  output logic              sdo,
  output logic              sdo_n
);
  logic       slot;
  logic       ser_bit;
  logic       scr_bit;
  svid_line_t line;

  svid_word_timer #(.DIV(WORD_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_slot(slot)
  );

  svid_shifter #(.W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(slot), .word_vld(word_valid),
    .word(word_data), .ser_bit(ser_bit)
  );

  svid_scrambler #(.LEN(HIST_W), .TAP(MID_TAP)) scr_i (
    .clk(clk), .rst_n(rst_n), .din(ser_bit), .dout(scr_bit)
  );

  svid_line_out out_i (
    .clk(clk), .rst_n(rst_n), .scr_bit(scr_bit), .raw_bit(ser_bit),
    .bypass(bypass), .lock(lock), .line(line)
  );

  assign word_ready = slot;
  assign sdo        = line.tru;
  assign sdo_n      = line.cmp;
endmodule

// File: rtl/svid_serializer_chk.sv
module svid_serializer_chk #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              word_ready,
  input logic              bypass,
  input logic              lock,
  input logic              ser_bit,
  input logic              sdo,
  input logic              sdo_n
);
  p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (!sdo && sdo_n));

  p_complement_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_n == !sdo);

  p_slot_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> !word_ready);

  p_lsb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |=> ser_bit == $past(word_data[0]));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !word_valid) |=> !ser_bit);

  p_bypass_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && bypass) |=> sdo == $past(ser_bit));
endmodule

bind svid_serializer svid_serializer_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .bypass(bypass), .lock(lock), .ser_bit(ser_bit),
  .sdo(sdo), .sdo_n(sdo_n)
);

// File: tb/svid_serializer_tb.sv
module svid_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] word_data = '0;
  logic       word_valid = 1'b0;
  logic       bypass = 1'b0;
  logic       lock = 1'b0;
  logic       word_ready, sdo, sdo_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  svid_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .bypass(bypass), .lock(lock),
    .sdo(sdo), .sdo_n(sdo_n)
  );

  // Reference model: pending raw bits, scrambled-bit history, line level
  bit    pend[$];
  bit    past_s[$];
  bit    level;
  bit    exp_sdo;
  bit    exp_ready;
  int    cyc;
  string tag;

  always @(posedge clk) begin
    bit b, s;
    if (!rst_n) begin
      pend.delete();
      past_s.delete();
      for (int i = 0; i < 9; i++) past_s.push_back(1'b0);
      level = 0; exp_sdo = 0; cyc = 0; exp_ready = 0; tag = "R1";
    end else begin
      b = (pend.size() != 0) ? pend.pop_front() : 1'b0;
      s = b ^ past_s[3] ^ past_s[8];       // R4
      past_s.push_front(s);
      void'(past_s.pop_back());
      level = level ^ s;                    // R5, state kept through mute (R8)
      if (!lock)       begin exp_sdo = 0;     tag = "R7"; end
      else if (bypass) begin exp_sdo = b;     tag = "R6/R3"; end
      else             begin exp_sdo = level; tag = "R4/R5"; end
      if (exp_ready) begin
        for (int i = 0; i < 10; i++)
          pend.push_back(word_valid ? word_data[i] : 1'b0);  // R10 on idle slot
      end
      cyc++;
      exp_ready = ((cyc % 10) == 9);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, sdo, exp_sdo);
      check("R9", sdo_n, !exp_sdo);
      check("R2", word_ready, exp_ready);
    end
  end

  int unsigned seed = 32'h1234_5678;
  function automatic logic [9:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[25:16];
  endfunction

  task automatic send(input logic [9:0] w);
    word_data  = w;
    word_valid = 1'b1;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sdo, 0);
    check("R1", sdo_n, 1);
    check("R1", word_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sdo, 0);

    // bypass: raw LSB-first stream (R3, R6)
    lock = 1'b1; bypass = 1'b1;
    send(10'h001); send(10'h3FF); send(10'h000); send(10'h2AA); send(10'h200);
    for (int i = 0; i < 6; i++) send(next_word());

    // scrambled + NRZI (R4, R5), long constant runs included
    bypass = 1'b0;
    send(10'h000); send(10'h000); send(10'h3FF); send(10'h3FF);
    for (int i = 0; i < 20; i++) send(next_word());

    // idle load slots serialize zeros (R10)
    repeat (35) @(negedge clk);
    send(10'h155);

    // lock loss mid-word, then recovery with state retained (R7, R8)
    word_data = next_word(); word_valid = 1'b1;
    while (!word_ready) @(negedge clk);
    @(negedge clk); word_valid = 1'b0;
    repeat (4) @(negedge clk);
    lock = 1'b0;
    for (int i = 0; i < 3; i++) send(next_word());
    lock = 1'b1;
    for (int i = 0; i < 8; i++) send(next_word());

    // bypass switched between words (R6)
    for (int i = 0; i < 10; i++) begin
      bypass = i[0];
      send(next_word());
    end
    repeat (12) @(negedge clk);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end
endmodule